// File: doc/BRIEF.md
# Configurable Single-Bit Storage Cell

This block holds one bit of state and is shaped by static parameters into either an edge-triggered flip-flop or a level-sensitive latch. Two control inputs steer the stored bit: `sr` drives it to a parameter-chosen polarity, and `rev` drives it to the opposite polarity. A mode parameter decides which of the two resulting functions (drive to 1, drive to 0) are honoured, and whether they act on the clock or immediately. Seven modes are offered: no control, synchronous set, synchronous reset, synchronous set and reset, asynchronous preset, asynchronous clear, and asynchronous preset and clear.

A separate parameter gives the value loaded while the active-low `rst_n` line is held low, which models configuration-time initialisation. That value is independent of the polarity that `sr` forces. The clock enable gates data capture and synchronous controls only. Asynchronous controls act at any time.

The cell is meant to be instantiated many times with different parameter sets inside a larger fabric model. The logic that computes `d` sits outside it.

Top module: `cfg_store_cell`

## Requirements
- R1: While `rst_n` is low, `q` equals `INIT_VAL`, overriding every other input, whatever `SR_VAL` is.
- R2: Flip-flop variant (`IS_LATCH`=0): with `ce`=1 and no honoured control, `q` takes `d` at the rising clock edge. Latch variant: with `ce`=1 and no honoured control, `q` follows `d` while `clk` is 1.
- R3: With `ce`=0, data capture and synchronous controls are blocked and `q` keeps its value.
- R4: Asserting `sr` requests `q`=`SR_VAL` and asserting `rev` requests `q`=~`SR_VAL`. A request for 1 is a "set" and a request for 0 is a "reset". A request whose function the mode does not enable is ignored.
- R5: In mode `SRM_NONE` (code 0), `sr` and `rev` have no effect.
- R6: Synchronous modes (codes 1 set, 2 reset, 3 both) act only when capture is enabled (rising edge, or transparent phase for the latch, with `ce`=1). Reset beats set, and both beat `d`.
- R7: Asynchronous modes (codes 4 preset, 5 clear, 6 both) act without regard to `clk` or `ce`. Clear beats preset.
- R8: After an asynchronous control is withdrawn, `q` keeps the forced value until the next capture. In the flip-flop variant, withdrawing a clear while a preset stays asserted leaves `q` at 0 until the next clock edge.
- R9: Between captures (flip-flop) or while `clk` is 0 (latch), changes on `d`, `sr` or `rev` in synchronous modes leave `q` unchanged. A flip-flop ignores a change of `d` while `clk` is high, while a transparent latch follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock edge (flip-flop) or gate level (latch) |
| rst_n | input | 1 | Active-low initialisation, loads `INIT_VAL` |
| d | input | 1 | Data input |
| ce | input | 1 | Capture enable for data and synchronous controls |
| sr | input | 1 | Drives `q` toward `SR_VAL` when its function is enabled |
| rev | input | 1 | Drives `q` toward ~`SR_VAL` when its function is enabled |
| q | output | 1 | Stored bit |

## Verification
On every clock edge, the assertions check the initialisation value, the hold under `ce`=0, data capture, the result of synchronous reset and set with reset winning, and the asynchronous clear/preset outcome with clear winning. Some behaviour happens between edges: the latch following `d` during the high phase, and a flip-flop keeping 0 after a clear drops while a preset stays asserted. Only the bench scenarios show these, by sampling just after each input change on 28 cells that cover every mode, both polarities and both variants.

// File: rtl/cfg_cell_pkg.sv
`timescale 1ns/1ps
package cfg_cell_pkg;

    typedef enum logic [2:0] {
        SRM_NONE       = 3'd0,
        SRM_SYNC_SET   = 3'd1,
        SRM_SYNC_RST   = 3'd2,
        SRM_SYNC_BOTH  = 3'd3,
        SRM_ASYNC_PRE  = 3'd4,
        SRM_ASYNC_CLR  = 3'd5,
        SRM_ASYNC_BOTH = 3'd6
    } srmode_e;

    // Resolved requests after polarity and mode masking
    typedef struct packed {
        logic set_s;
        logic rst_s;
        logic set_a;
        logic rst_a;
    } ctrl_req_t;

    // Next-value bundle computed by the combinational stage
    typedef struct packed {
        logic pass;   // value taken when capture is open
        logic open;   // capture enabled
    } cell_next_t;

    function automatic logic mode_has_set(srmode_e m);
        return (m == SRM_SYNC_SET) || (m == SRM_SYNC_BOTH) ||
               (m == SRM_ASYNC_PRE) || (m == SRM_ASYNC_BOTH);
    endfunction

    function automatic logic mode_has_rst(srmode_e m);
        return (m == SRM_SYNC_RST) || (m == SRM_SYNC_BOTH) ||
               (m == SRM_ASYNC_CLR) || (m == SRM_ASYNC_BOTH);
    endfunction

    function automatic logic mode_is_async(srmode_e m);
        return (m == SRM_ASYNC_PRE) || (m == SRM_ASYNC_CLR) ||
               (m == SRM_ASYNC_BOTH);
    endfunction

endpackage

// File: rtl/cfg_ctrl_decode.sv
`timescale 1ns/1ps
module cfg_ctrl_decode
    import cfg_cell_pkg::*;
#(
    parameter srmode_e SR_MODE = SRM_NONE,
    parameter logic    SR_VAL  = 1'b0
) (
    input  logic      sr,
    input  logic      rev,
    output ctrl_req_t req
);
    localparam logic USE_SET  = mode_has_set(SR_MODE);
    localparam logic USE_RST  = mode_has_rst(SR_MODE);
    localparam logic IS_ASYNC = mode_is_async(SR_MODE);

    logic set_raw;
    logic rst_raw;

    // sr pushes toward SR_VAL, rev toward its complement
    assign set_raw = SR_VAL ? sr  : rev;
    assign rst_raw = SR_VAL ? rev : sr;

    always_comb begin
        req       = '0;
        req.set_s = USE_SET & ~IS_ASYNC & set_raw;
        req.rst_s = USE_RST & ~IS_ASYNC & rst_raw;
        req.set_a = USE_SET &  IS_ASYNC & set_raw;
        req.rst_a = USE_RST &  IS_ASYNC & rst_raw;
    end
endmodule

// File: rtl/cfg_next_value.sv
`timescale 1ns/1ps
module cfg_next_value
    import cfg_cell_pkg::*;
(
    input  logic       d,
    input  logic       ce,
    input  ctrl_req_t  req,
    output cell_next_t nxt
);
    logic unused_async;
    assign unused_async = req.set_a ^ req.rst_a;

    always_comb begin
        nxt      = '0;
        nxt.open = ce;
        // reset over set over data
        if (req.rst_s)      nxt.pass = 1'b0;
        else if (req.set_s) nxt.pass = 1'b1;
        else                nxt.pass = d;
    end
endmodule

// File: rtl/cfg_store_core.sv
`timescale 1ns/1ps
module cfg_store_core
    import cfg_cell_pkg::*;
#(
    parameter logic IS_LATCH = 1'b0,
    parameter logic INIT_VAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_a,
    input  logic       pre_a,
    input  cell_next_t nxt,
    output logic       q
);
    logic q_q;
    assign q = q_q;

    if (IS_LATCH) begin : g_latch
        always_latch begin
            if (!rst_n)               q_q <= INIT_VAL;
            else if (clr_a)           q_q <= 1'b0;
            else if (pre_a)           q_q <= 1'b1;
            else if (clk && nxt.open) q_q <= nxt.pass;
        end
    end else begin : g_flop
        logic q_d;
        always_comb begin
            q_d = nxt.open ? nxt.pass : q_q;
        end
        always_ff @(posedge clk or negedge rst_n or posedge clr_a or posedge pre_a) begin
            if (!rst_n)     q_q <= INIT_VAL;
            else if (clr_a) q_q <= 1'b0;
            else if (pre_a) q_q <= 1'b1;
            else            q_q <= q_d;
        end
    end
endmodule

// File: rtl/cfg_store_cell.sv
`timescale 1ns/1ps
module cfg_store_cell
    import cfg_cell_pkg::*;
#(
    parameter logic    IS_LATCH = 1'b0,
    parameter srmode_e SR_MODE  = SRM_NONE,
    parameter logic    SR_VAL   = 1'b0,
    parameter logic    INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic ce,
    input  logic sr,
    input  logic rev,
    output logic q
);
    ctrl_req_t  req;
    cell_next_t nxt;
    logic       clr_a;
    logic       pre_a;

    cfg_ctrl_decode #(.SR_MODE(SR_MODE), .SR_VAL(SR_VAL)) u_decode (
        .sr  (sr),
        .rev (rev),
        .req (req)
    );

    cfg_next_value u_next (
        .d   (d),
        .ce  (ce),
        .req (req),
        .nxt (nxt)
    );

    assign clr_a = req.rst_a;
    assign pre_a = req.set_a;

    cfg_store_core #(.IS_LATCH(IS_LATCH), .INIT_VAL(INIT_VAL)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_a (clr_a),
        .pre_a (pre_a),
        .nxt   (nxt),
        .q     (q)
    );
endmodule

// File: rtl/cfg_store_chk.sv
`timescale 1ns/1ps
module cfg_store_chk
    import cfg_cell_pkg::*;
#(
    parameter logic    IS_LATCH = 1'b0,
    parameter srmode_e SR_MODE  = SRM_NONE,
    parameter logic    SR_VAL   = 1'b0,
    parameter logic    INIT_VAL = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic d,
    input logic ce,
    input logic sr,
    input logic rev,
    input logic q
);
    localparam logic USE_SET  = mode_has_set(SR_MODE);
    localparam logic USE_RST  = mode_has_rst(SR_MODE);
    localparam logic IS_ASYNC = mode_is_async(SR_MODE);

    logic set_on;
    logic rst_on;
    assign set_on = USE_SET & (SR_VAL ? sr : rev);
    assign rst_on = USE_RST & (SR_VAL ? rev : sr);

    AST_INIT_LOAD: assert property (@(posedge clk)
        !rst_n |-> q == INIT_VAL); // R1

    if (IS_ASYNC) begin : g_async
        AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            rst_on |=> (q == 1'b0) || (set_on && !rst_on)); // R7
        AST_ASYNC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
            set_on && !rst_on |=> (q == 1'b1) || rst_on); // R7
    end else if (!IS_LATCH) begin : g_sync
        AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !ce |=> q == $past(q)); // R3
        AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            ce && !set_on && !rst_on |=> q == $past(d)); // R2
        AST_SYNC_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ce && rst_on |=> q == 1'b0); // R6
        AST_SYNC_SET: assert property (@(posedge clk) disable iff (!rst_n)
            ce && set_on && !rst_on |=> q == 1'b1); // R4
    end
endmodule

bind cfg_store_cell cfg_store_chk #(
    .IS_LATCH (IS_LATCH),
    .SR_MODE  (SR_MODE),
    .SR_VAL   (SR_VAL),
    .INIT_VAL (INIT_VAL)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (d),
    .ce    (ce),
    .sr    (sr),
    .rev   (rev),
    .q     (q)
);

// File: tb/cfg_store_cell_tb.sv
`timescale 1ns/1ps
module cfg_store_cell_tb;
    import cfg_cell_pkg::*;

    localparam int NI = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic d = 1'b0, ce = 1'b0, sr = 1'b0, rev = 1'b0;
    logic [NI-1:0] q_vec;

    logic exp_q [NI];
    logic p_sr = 1'b0, p_rev = 1'b0;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic init_of(int k, int m);
        return logic'((k + m) % 2);
    endfunction

    for (genvar k = 0; k < 2; k++) begin : g_k
        for (genvar m = 0; m < 7; m++) begin : g_m
            for (genvar s = 0; s < 2; s++) begin : g_s
                cfg_store_cell #(
                    .IS_LATCH ((k == 1) ? 1'b1 : 1'b0),
                    .SR_MODE  (srmode_e'(m)),
                    .SR_VAL   ((s == 1) ? 1'b1 : 1'b0),
                    .INIT_VAL (init_of(k, m))
                ) u_dut (
                    .clk (clk), .rst_n (rst_n), .d (d), .ce (ce),
                    .sr (sr), .rev (rev), .q (q_vec[k*14 + m*2 + s])
                );
            end
        end
    end

    // Requests from the requirement text (R4)
    function automatic void reqs(input int m, input int s, input logic isr, input logic irev,
                                 output logic st, output logic rs, output logic asy);
        logic sraw, rraw, us, ur;
        sraw = (s == 1) ? isr  : irev;
        rraw = (s == 1) ? irev : isr;
        us   = (m == 1) || (m == 3) || (m == 4) || (m == 6);
        ur   = (m == 2) || (m == 3) || (m == 5) || (m == 6);
        asy  = (m >= 4);
        st   = us & sraw;
        rs   = ur & rraw;
    endfunction

    function automatic logic pass_of(logic st, logic rs, logic asy);
        if (!asy && rs) return 1'b0;
        if (!asy && st) return 1'b1;
        return d;
    endfunction

    // phase 0: after input change at clk low, 1: after rising edge, 2: after d change with clk high
    task automatic update(input int phase);
        for (int i = 0; i < NI; i++) begin
            int k, m, s;
            logic st, rs, asy, pst, prs, pasy;
            k = i / 14; m = (i % 14) / 2; s = i % 2;
            reqs(m, s, sr, rev, st, rs, asy);
            reqs(m, s, p_sr, p_rev, pst, prs, pasy);
            if (!rst_n) exp_q[i] = init_of(k, m);
            else if (k == 1) begin
                if (asy && rs)                  exp_q[i] = 1'b0;
                else if (asy && st)             exp_q[i] = 1'b1;
                else if (phase != 0 && ce)      exp_q[i] = pass_of(st, rs, asy);
            end else if (phase == 0) begin
                if (asy && rs && !prs)          exp_q[i] = 1'b0;
                else if (asy && st && !pst && !rs) exp_q[i] = 1'b1;
            end else if (phase == 1) begin
                if (asy && rs)                  exp_q[i] = 1'b0;
                else if (asy && st)             exp_q[i] = 1'b1;
                else if (ce)                    exp_q[i] = pass_of(st, rs, asy);
            end
        end
    endtask

    function automatic string tag_of(int phase, int m, int s);
        logic st, rs, asy;
        reqs(m, s, sr, rev, st, rs, asy);
        if (!rst_n)            return "R1";
        if (phase == 2)        return "R9";
        if (m == 0)            return "R5";
        if (asy) begin
            if (st || rs)      return "R7";
            if (phase == 0)    return "R8";
            return ce ? "R2" : "R3";
        end
        if (phase == 0)        return "R9";
        if (!ce)               return "R3";
        if (rs)                return "R6";
        if (st || sr || rev)   return "R4";
        return "R2";
    endfunction

    task automatic check_all(input int phase);
        for (int i = 0; i < NI; i++) begin
            int m, s;
            m = (i % 14) / 2; s = i % 2;
            checks++;
            if (q_vec[i] !== exp_q[i]) begin
                errors++;
                $display("FAIL %s cell %0d (latch=%0d mode=%0d srval=%0d phase=%0d) q=%b expected=%b",
                         tag_of(phase, m, s), i, i / 14, m, s, phase, q_vec[i], exp_q[i]);
            end
        end
    endtask

    task automatic step(input logic id, input logic ice, input logic isr, input logic irev,
                        input logic irst, input logic id2);
        @(negedge clk);
        d = id; ce = ice; sr = isr; rev = irev; rst_n = irst;
        #1; update(0); check_all(0);
        p_sr = sr; p_rev = rev;
        @(posedge clk);
        #1; update(1); check_all(1);
        d = id2;
        #1; update(2); check_all(2);
    endtask

    initial begin
        void'($urandom(32'h0005_EED1));
        #1 rst_n = 1'b0;
        // R1: initial value under reset
        step(1, 1, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        // R2 data capture and latch transparency (R9)
        step(1, 1, 0, 0, 1, 0);
        step(0, 1, 0, 0, 1, 1);
        // R3 enable low blocks everything synchronous
        step(1, 0, 1, 0, 1, 1);
        step(0, 0, 0, 1, 1, 0);
        // R6 both controls with capture enabled: reset wins; R7 clear wins
        step(1, 1, 1, 1, 1, 1);
        // R8: clear withdrawn while preset held
        step(1, 1, 1, 0, 1, 1);
        step(0, 1, 0, 1, 1, 0);
        step(1, 0, 1, 1, 1, 0);
        step(1, 0, 1, 0, 1, 1);
        step(0, 0, 0, 0, 1, 1);
        // R4 single controls alone
        step(0, 1, 1, 0, 1, 0);
        step(1, 1, 0, 1, 1, 1);
        // R1 reset mid-run with controls held, then release under clear
        step(0, 1, 1, 1, 0, 1);
        step(0, 1, 1, 1, 1, 0);
        // Random mix (R2..R9)
        for (int n = 0; n < 800; n++) begin
            step(logic'($urandom % 2), logic'(($urandom % 4) != 0),
                 logic'(($urandom % 3) == 0), logic'(($urandom % 3) == 0),
                 logic'(($urandom % 25) != 0), logic'($urandom % 2));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule